// File: doc/BRIEF.md
# DMA Channel Address and Count Sequencer

This block is the transfer engine of one DMA channel. Software keeps a peripheral base address and a memory base address in registers outside the block and loads an item count into the block. While the channel is enabled, the block holds two working address pointers and a remaining-item counter, none of which software can write. Each completed single transfer moves the counter and the pointers on by one step. The block offers an acknowledge for incoming requests and a pulse when a block finishes.

The peripheral side and the memory side each have their own data size and their own increment enable. The programmed count and the base inputs are never modified by the block. When the channel is enabled, the working registers are seeded from the programmed values. In one-shot mode the channel stops serving requests when the count runs out. In circular mode the channel reseeds itself and keeps running.

Top module: `dma_xfer_seq`

## Requirements
- R1: Each `xfer_done` accepted while the channel is running with a nonzero remaining count lowers `rem_cnt` by exactly one, except on the last item of a circular block (see R8).
- R2: A size field selects the step: 2'b00 byte (step 1), 2'b01 half-word (step 2), 2'b10 word (step 4). The value 2'b11 is treated as word (step 4). The effective size is presented on `per_size_eff` / `mem_size_eff`, where 2'b11 appears as 2'b10.
- R3: On an accepted transfer, a side whose increment enable is 1 advances its working address by that side's step. A side whose increment enable is 0 keeps its address.
- R4: The first transfer after enabling uses the base address of each side. The base inputs are only read and are never altered.
- R5: In one-shot mode, once `rem_cnt` is 0, `req_ack` stays low, and further `xfer_done` strobes change neither the count nor the addresses. A block programmed with count 0 serves nothing.
- R6: `cnt_wr` loads `cnt_wdata` into the programmed count only while `chan_en` is 0. A write while the channel is enabled is ignored.
- R7: While `chan_en` is 0, the remaining count and both working addresses hold their values. The programmed count survives disabling.
- R8: In circular mode, the transfer that finishes a block reloads `rem_cnt` with the programmed count and reloads both working addresses with the base addresses.
- R9: In the cycle after `chan_en` rises, `rem_cnt` equals the programmed count, and both working addresses equal their bases.
- R10: `blk_done` is a one-cycle pulse in the cycle after the transfer that takes the count from 1 to its end, in both modes.
- R11: `req_ack` is combinationally high exactly when `req` is high, the channel has been enabled for at least one cycle, and `rem_cnt` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_en | input | 1 | Channel enable |
| circ_mode | input | 1 | 1 = circular, 0 = one-shot |
| per_size | input | 2 | Peripheral data size code |
| mem_size | input | 2 | Memory data size code |
| per_inc | input | 1 | Peripheral pointer increment enable |
| mem_inc | input | 1 | Memory pointer increment enable |
| per_base | input | AW | Programmed peripheral base address |
| mem_base | input | AW | Programmed memory base address |
| cnt_wr | input | 1 | Item count write strobe |
| cnt_wdata | input | CW | Item count write value |
| req | input | 1 | Transfer request |
| xfer_done | input | 1 | Single transfer completed |
| per_addr | output | AW | Current peripheral address |
| mem_addr | output | AW | Current memory address |
| per_size_eff | output | 2 | Effective peripheral size |
| mem_size_eff | output | 2 | Effective memory size |
| req_ack | output | 1 | Request accepted |
| blk_done | output | 1 | Block-complete pulse |
| rem_cnt | output | CW | Remaining item count |

## Verification
The hardest state to reach from the ports is the end of a block. This is the one transfer where reload, pulse and stop behaviour all meet, and it has to be seen under every combination of sizes, increment enables and mode. The bench walks all 128 such combinations with a count of three. It drives every block through its final transfer and then one transfer beyond it, so the wrap in circular mode and the stall in one-shot mode are both observed. Directed sequences cover the other cases: a count write while enabled, a disable in the middle of a block, and a zero count.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WIDE = 2'b11
    } xfer_size_e;

    // Byte step of one item; the spare code behaves as a word
    function automatic logic [2:0] size_step(input logic [1:0] sz);
        case (xfer_size_e'(sz))
            SZ_BYTE: return 3'd1;
            SZ_HALF: return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [1:0] size_norm(input logic [1:0] sz);
        return (xfer_size_e'(sz) == SZ_WIDE) ? SZ_WORD : sz;
    endfunction

endpackage

// File: rtl/dma_addr_lane.sv
module dma_addr_lane
    import dma_seq_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          adv,
    input  logic          inc,
    input  logic [1:0]    size,
    input  logic [AW-1:0] base,
    output logic [AW-1:0] addr,
    output logic [1:0]    size_eff
);

    logic [AW-1:0] addr_d, addr_q;

    always_comb begin
        addr_d = addr_q;
        if (load) begin
            addr_d = base;
        end else if (adv && inc) begin
            addr_d = addr_q + AW'(size_step(size));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else begin
            addr_q <= addr_d;
        end
    end

    assign addr     = addr_q;
    assign size_eff = size_norm(size);

endmodule

// File: rtl/dma_cnt_ctrl.sv
module dma_cnt_ctrl #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          circ,
    input  logic          cnt_wr,
    input  logic [CW-1:0] cnt_wdata,
    input  logic          req,
    input  logic          done,
    output logic          load,
    output logic          adv,
    output logic          req_ack,
    output logic          blk_done,
    output logic [CW-1:0] rem,
    output logic          en_q,
    output logic [CW-1:0] prog_q
);

    typedef struct packed {
        logic          en;
        logic          blk;
        logic [CW-1:0] rem;
        logic [CW-1:0] prog;
    } ctl_t;

    ctl_t s_d, s_q;
    logic live;

    always_comb begin
        s_d     = s_q;
        s_d.en  = en;
        s_d.blk = 1'b0;
        load    = 1'b0;
        adv     = 1'b0;
        live    = en && s_q.en;

        if (cnt_wr && !en) begin
            s_d.prog = cnt_wdata;
        end

        if (en && !s_q.en) begin
            s_d.rem = s_q.prog;
            load    = 1'b1;
        end else if (live && done && (s_q.rem != '0)) begin
            adv = 1'b1;
            if (s_q.rem == CW'(1)) begin
                s_d.blk = 1'b1;
                if (circ) begin
                    s_d.rem = s_q.prog;
                    load    = 1'b1;
                end else begin
                    s_d.rem = '0;
                end
            end else begin
                s_d.rem = s_q.rem - CW'(1);
            end
        end

        req_ack = live && req && (s_q.rem != '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign blk_done = s_q.blk;
    assign rem      = s_q.rem;
    assign en_q     = s_q.en;
    assign prog_q   = s_q.prog;

endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq #(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chan_en,
    input  logic          circ_mode,
    input  logic [1:0]    per_size,
    input  logic [1:0]    mem_size,
    input  logic          per_inc,
    input  logic          mem_inc,
    input  logic [AW-1:0] per_base,
    input  logic [AW-1:0] mem_base,
    input  logic          cnt_wr,
    input  logic [CW-1:0] cnt_wdata,
    input  logic          req,
    input  logic          xfer_done,
    output logic [AW-1:0] per_addr,
    output logic [AW-1:0] mem_addr,
    output logic [1:0]    per_size_eff,
    output logic [1:0]    mem_size_eff,
    output logic          req_ack,
    output logic          blk_done,
    output logic [CW-1:0] rem_cnt
);

    localparam int NLANE = 2;

    logic          lane_load, lane_adv;
    logic          en_q;
    logic [CW-1:0] prog_q;

    logic [AW-1:0] l_base [NLANE];
    logic [AW-1:0] l_addr [NLANE];
    logic [1:0]    l_size [NLANE];
    logic [1:0]    l_seff [NLANE];
    logic          l_inc  [NLANE];

    assign l_base[0] = per_base;
    assign l_base[1] = mem_base;
    assign l_size[0] = per_size;
    assign l_size[1] = mem_size;
    assign l_inc[0]  = per_inc;
    assign l_inc[1]  = mem_inc;

    dma_cnt_ctrl #(.CW(CW)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (chan_en),
        .circ      (circ_mode),
        .cnt_wr    (cnt_wr),
        .cnt_wdata (cnt_wdata),
        .req       (req),
        .done      (xfer_done),
        .load      (lane_load),
        .adv       (lane_adv),
        .req_ack   (req_ack),
        .blk_done  (blk_done),
        .rem       (rem_cnt),
        .en_q      (en_q),
        .prog_q    (prog_q)
    );

    for (genvar i = 0; i < NLANE; i++) begin : g_lane
        dma_addr_lane #(.AW(AW)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (lane_load),
            .adv      (lane_adv),
            .inc      (l_inc[i]),
            .size     (l_size[i]),
            .base     (l_base[i]),
            .addr     (l_addr[i]),
            .size_eff (l_seff[i])
        );
    end

    assign per_addr     = l_addr[0];
    assign mem_addr     = l_addr[1];
    assign per_size_eff = l_seff[0];
    assign mem_size_eff = l_seff[1];

endmodule

// File: rtl/dma_xfer_seq_chk.sv
module dma_xfer_seq_chk #(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          chan_en,
    input logic          circ_mode,
    input logic          req,
    input logic          xfer_done,
    input logic          req_ack,
    input logic          blk_done,
    input logic [CW-1:0] rem_cnt,
    input logic [AW-1:0] per_addr,
    input logic [AW-1:0] mem_addr,
    input logic [AW-1:0] per_base,
    input logic          en_q,
    input logic [CW-1:0] prog_q
);

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_en && en_q && xfer_done && rem_cnt > CW'(1)) |=> rem_cnt == $past(rem_cnt) - CW'(1)); // R1

    AST_ONESHOT_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (rem_cnt == '0) |-> !req_ack); // R5

    AST_CNT_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        chan_en |=> $stable(prog_q)); // R6

    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en |=> ($stable(rem_cnt) && $stable(per_addr) && $stable(mem_addr))); // R7

    AST_CIRC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_en && en_q && circ_mode && xfer_done && rem_cnt == CW'(1))
        |=> (rem_cnt == $past(prog_q) && per_addr == $past(per_base))); // R8

    AST_RISE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_en && !en_q) |=> rem_cnt == $past(prog_q)); // R9

    AST_BLK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        blk_done |-> $past(chan_en && en_q && xfer_done && rem_cnt == CW'(1))); // R10

    AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |-> (req && en_q)); // R11

endmodule

bind dma_xfer_seq dma_xfer_seq_chk #(.AW(AW), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .chan_en   (chan_en),
    .circ_mode (circ_mode),
    .req       (req),
    .xfer_done (xfer_done),
    .req_ack   (req_ack),
    .blk_done  (blk_done),
    .rem_cnt   (rem_cnt),
    .per_addr  (per_addr),
    .mem_addr  (mem_addr),
    .per_base  (per_base),
    .en_q      (en_q),
    .prog_q    (prog_q)
);

// File: tb/sim_dma_xfer_seq.sv
`timescale 1ns/1ps
module sim_dma_xfer_seq;

    localparam int AW = 32;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          chan_en = 1'b0, circ_mode = 1'b0;
    logic [1:0]    per_size = '0, mem_size = '0;
    logic          per_inc = 1'b0, mem_inc = 1'b0;
    logic [AW-1:0] per_base = '0, mem_base = '0;
    logic          cnt_wr = 1'b0;
    logic [CW-1:0] cnt_wdata = '0;
    logic          req = 1'b0, xfer_done = 1'b0;
    logic [AW-1:0] per_addr, mem_addr;
    logic [1:0]    per_size_eff, mem_size_eff;
    logic          req_ack, blk_done;
    logic [CW-1:0] rem_cnt;

    int nvec = 0;
    int nerr = 0;

    always #2.5 clk = ~clk;

    dma_xfer_seq #(.AW(AW), .CW(CW)) u0 (.*);

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string rid, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", rid, act, exp);
        end
    endtask

    function automatic logic [31:0] stepof(input logic [1:0] sz);
        return (sz == 2'd0) ? 32'd1 : (sz == 2'd1) ? 32'd2 : 32'd4;
    endfunction

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        logic [31:0] ps, ms, ep, em;
        tick(); tick();
        rst_n = 1'b1;
        tick();
        chk("R9 reset rem", 32'(rem_cnt), 0);
        chk("R11 reset ack", 32'(req_ack), 0);
        chk("R10 reset blk", 32'(blk_done), 0);
        chk("R4 reset paddr", per_addr, 0);

        // Sweep all size/increment/mode combinations
        for (int c = 0; c < 128; c++) begin
            per_size  = c[1:0];
            mem_size  = c[3:2];
            per_inc   = c[4];
            mem_inc   = c[5];
            circ_mode = c[6];
            per_base  = 32'h1000 + 32'(c) * 256;
            mem_base  = 32'hA000_0000 + 32'(c) * 16;
            ps = stepof(per_size);
            ms = stepof(mem_size);
            cnt_wdata = 16'd3; cnt_wr = 1'b1; tick(); cnt_wr = 1'b0;
            chan_en = 1'b1; tick();
            chk("R9 load rem", 32'(rem_cnt), 3);
            chk("R4 first paddr", per_addr, per_base);
            chk("R4 first maddr", mem_addr, mem_base);
            chk("R2 psize eff", 32'(per_size_eff), (per_size == 2'd3) ? 2 : 32'(per_size));
            chk("R2 msize eff", 32'(mem_size_eff), (mem_size == 2'd3) ? 2 : 32'(mem_size));
            for (int k = 1; k <= 3; k++) begin
                req = 1'b1; xfer_done = 1'b1; #1;
                chk("R11 ack", 32'(req_ack), 1);
                tick();
                req = 1'b0; xfer_done = 1'b0;
                if (k < 3 || !circ_mode) begin
                    ep = per_base + (per_inc ? 32'(k) * ps : 0);
                    em = mem_base + (mem_inc ? 32'(k) * ms : 0);
                    chk("R1 rem", 32'(rem_cnt), 32'(3 - k));
                end else begin
                    ep = per_base; em = mem_base;
                    chk("R8 rem reload", 32'(rem_cnt), 3);
                end
                chk("R3 paddr", per_addr, ep);
                chk("R3 maddr", mem_addr, em);
                chk("R10 blk", 32'(blk_done), (k == 3) ? 1 : 0);
            end
            req = 1'b1; xfer_done = 1'b1; #1;
            chk("R5 ack after end", 32'(req_ack), circ_mode ? 1 : 0);
            tick();
            req = 1'b0; xfer_done = 1'b0;
            if (circ_mode) begin
                chk("R8 rem wrap", 32'(rem_cnt), 2);
                chk("R8 paddr wrap", per_addr, per_base + (per_inc ? ps : 0));
                chk("R8 maddr wrap", mem_addr, mem_base + (mem_inc ? ms : 0));
            end else begin
                chk("R5 rem stays", 32'(rem_cnt), 0);
                chk("R5 paddr stays", per_addr, per_base + (per_inc ? 3 * ps : 0));
                chk("R5 maddr stays", mem_addr, mem_base + (mem_inc ? 3 * ms : 0));
            end
            chk("R10 single pulse", 32'(blk_done), 0);
            ep = 32'(rem_cnt);
            chan_en = 1'b0; tick();
            chk("R7 rem held", 32'(rem_cnt), ep);
        end

        // Count write while enabled; disable mid-block
        circ_mode = 1'b0; per_size = 2'd2; per_inc = 1'b1; per_base = 32'h2000;
        cnt_wdata = 16'd3; cnt_wr = 1'b1; tick(); cnt_wr = 1'b0;
        chan_en = 1'b1; tick();
        cnt_wdata = 16'd9; cnt_wr = 1'b1; tick(); cnt_wr = 1'b0;
        chk("R6 rem untouched", 32'(rem_cnt), 3);
        xfer_done = 1'b1; tick(); xfer_done = 1'b0;
        chk("R1 rem mid", 32'(rem_cnt), 2);
        chk("R3 paddr mid", per_addr, 32'h2004);
        chan_en = 1'b0; tick();
        xfer_done = 1'b1; req = 1'b1; #1;
        chk("R11 ack while off", 32'(req_ack), 0);
        tick(); tick();
        xfer_done = 1'b0; req = 1'b0;
        chk("R7 rem hold off", 32'(rem_cnt), 2);
        chk("R7 paddr hold off", per_addr, 32'h2004);
        chan_en = 1'b1; tick();
        chk("R6 prog kept", 32'(rem_cnt), 3);
        chk("R9 paddr reload", per_addr, 32'h2000);
        chan_en = 1'b0; tick();
        cnt_wdata = 16'd5; cnt_wr = 1'b1; tick(); cnt_wr = 1'b0;
        chan_en = 1'b1; tick();
        chk("R6 write while off", 32'(rem_cnt), 5);

        // Zero count
        chan_en = 1'b0; tick();
        cnt_wdata = 16'd0; cnt_wr = 1'b1; tick(); cnt_wr = 1'b0;
        chan_en = 1'b1; tick();
        req = 1'b1; xfer_done = 1'b1; #1;
        chk("R5 zero ack", 32'(req_ack), 0);
        tick();
        req = 1'b0; xfer_done = 1'b0;
        chk("R5 zero rem", 32'(rem_cnt), 0);
        chk("R10 zero blk", 32'(blk_done), 0);
        chk("R5 zero paddr", per_addr, 32'h2000);

        finish_run();
    end

endmodule